// File: doc/BRIEF.md
# DRAM Channel Select and Address Normalizer

This block sits after the node-range decoder of a memory controller. It takes a system address that is already known to belong to this node, the number of node-interleave bits, and the base of the matched DRAM range. From the controller-select configuration it picks one of two DRAM channels. It then subtracts the right offset, which is the range base, the high-range offset or the memory-hole offset. Last, it squeezes out the address bits used by node interleaving and channel interleaving. The result is a dense, channel-relative address for chip-select matching.

The channel choice follows a fixed priority. Ganging comes first, then a programmed high range, then one of several interleave schemes (including a parity hash over bits 20:16), then a fallback. The offset choice depends on whether the high range was taken, whether the memory hole is valid, and whether the address lies at or above 4 GiB. The datapath is combinational and ends in one output register, which loads only when `in_valid` is high.

Top module: `dram_chan_norm`

## Requirements
- R1: `hi_range` is 1 only when `hi_rng_en`=1, `gang_en`=0 and `sys_addr` >= `{sel_base_fld, 27'b0}`. With `gang_en`=1 it is always 0.
- R2: With `gang_en`=1 the channel is `sys_addr[3]`, and no channel-interleave bit is removed.
- R3: When the high range is selected, the channel equals `hi_chan`, and no channel-interleave bit is removed.
- R4: Interleave on (`ilv_en`=1) with `ilv_mode`=0, not ganged, not high range: the channel is `sys_addr[6]`, and bit 6 is removed from the channel address.
- R5: Interleave on with `ilv_mode[1]`=1: the channel is the XOR of bits 20:16 of `sys_addr`, XORed with `sys_addr[9]` when `ilv_mode[0]`=1 or with `sys_addr[6]` when it is 0. Mode 3 removes bit 9 and mode 2 removes bit 6.
- R6: Interleave on with `ilv_mode`=1: the channel is `sys_addr[12+node_ilog]`, and bit 12 of the node-stripped address is removed.
- R7: Without ganging, high range or interleave, the channel is `~hi_chan` when `hi_rng_en`=1, and 0 otherwise.
- R8: In the high range, the offset is `{hole_off_fld, 23'b0}` when `sel_base_fld` places the base below 4 GiB, `hole_valid`=1 and `sys_addr` >= 4 GiB. Otherwise the offset is `{sel_off_fld, 26'b0}`.
- R9: Outside the high range, the offset is `{hole_off_fld, 23'b0}` when `hole_valid`=1 and `sys_addr` >= 4 GiB. Otherwise it is `{range_base_fld, 24'b0}`.
- R10: With `node_ilog`=k, the k bits starting at bit 12 of (address minus offset) are removed. Bits 11:0 are kept and the upper bits shift down by k.
- R11: Outputs are registered and appear one clock after `in_valid`. `out_valid` mirrors `in_valid` delayed by one clock. While `in_valid`=0 the registered `chan`, `chan_addr` and `hi_range` hold. Reset clears all outputs to 0.
- R12: The subtraction is modulo 2^48. Because every offset has bits 22:0 at zero, bits 5:0 of `chan_addr` equal those of `sys_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Load the output register this cycle |
| sys_addr | input | 48 | Node-decoded system address |
| node_ilog | input | 2 | Number of node-interleave bits (0..3) |
| range_base_fld | input | 24 | Matched range base, address bits 47:24 |
| hi_rng_en | input | 1 | High-range channel split enable |
| hi_chan | input | 1 | Channel that owns the high range |
| ilv_en | input | 1 | Channel interleave enable |
| gang_en | input | 1 | Both channels ganged |
| ilv_mode | input | 2 | Interleave bit / hash selection |
| sel_base_fld | input | 21 | High-range start, address bits 47:27 |
| sel_off_fld | input | 22 | High-range offset, address bits 47:26 |
| hole_valid | input | 1 | Memory hole hoisting active |
| hole_off_fld | input | 9 | Hole offset, address bits 31:23 |
| out_valid | output | 1 | Registered outputs carry a new result |
| chan | output | 1 | Selected channel |
| chan_addr | output | 48 | Normalized channel address |
| hi_range | output | 1 | High range was selected |

## Verification
A wrong priority decision or a wrong offset choice in this block shows up one clock after the offending input. It appears either as a flipped `chan`, or as a `chan_addr` that is off by a whole offset or shifted by one bit position. The random mix covers every interleave mode against all values of `node_ilog`, and a reference model flags any such slip in the same cycle. Errors in hold or reset behaviour show on the next idle cycle as a changed output.

// File: rtl/dcn_pkg.sv
package dcn_pkg;
    localparam int ADDR_W  = 48;
    localparam int ILOG_W  = 2;
    localparam int GIB4_BIT = 32;

    typedef enum logic [2:0] {
        SRC_GANG,
        SRC_HIGH,
        SRC_ILV6,
        SRC_HASH,
        SRC_ILVN,
        SRC_HINV,
        SRC_ZERO
    } chan_src_e;
endpackage

// File: rtl/dcn_chan_sel.sv
module dcn_chan_sel
    import dcn_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int IW = ILOG_W,
    parameter int SBASE_SH = 27
) (
    input  logic [AW-1:0]          addr,
    input  logic [IW-1:0]          ilog,
    input  logic                   hi_rng_en,
    input  logic                   hi_chan,
    input  logic                   ilv_en,
    input  logic                   gang_en,
    input  logic [1:0]             ilv_mode,
    input  logic [AW-SBASE_SH-1:0] sel_base_fld,
    output logic                   hi_range,
    output logic                   chan,
    output chan_src_e              src
);
    localparam int HASH_LO = 16;
    localparam int HASH_HI = 20;

    logic [AW-1:0] sel_base;
    logic          hash_par;
    logic          nbit;

    assign sel_base = {sel_base_fld, {SBASE_SH{1'b0}}};
    assign hash_par = ^addr[HASH_HI:HASH_LO];
    assign nbit     = addr[12 + int'(ilog)];

    always_comb begin
        hi_range = hi_rng_en && !gang_en && (addr >= sel_base);
        if (gang_en)                             src = SRC_GANG;
        else if (hi_range)                       src = SRC_HIGH;
        else if (ilv_en && (ilv_mode == 2'd0))   src = SRC_ILV6;
        else if (ilv_en && ilv_mode[1])          src = SRC_HASH;
        else if (ilv_en)                         src = SRC_ILVN;
        else if (hi_rng_en)                      src = SRC_HINV;
        else                                     src = SRC_ZERO;
    end

    always_comb begin
        unique case (src)
            SRC_GANG: chan = addr[3];
            SRC_HIGH: chan = hi_chan;
            SRC_ILV6: chan = addr[6];
            SRC_HASH: chan = hash_par ^ (ilv_mode[0] ? addr[9] : addr[6]);
            SRC_ILVN: chan = nbit;
            SRC_HINV: chan = ~hi_chan;
            default:  chan = 1'b0;
        endcase
    end
endmodule

// File: rtl/dcn_offset.sv
module dcn_offset
    import dcn_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int G4 = GIB4_BIT,
    parameter int SBASE_SH = 27,
    parameter int SOFF_SH  = 26,
    parameter int HOLE_SH  = 23,
    parameter int RBASE_SH = 24
) (
    input  logic [AW-1:0]          addr,
    input  logic                   hi_range,
    input  logic [AW-SBASE_SH-1:0] sel_base_fld,
    input  logic [AW-SOFF_SH-1:0]  sel_off_fld,
    input  logic                   hole_valid,
    input  logic [G4-HOLE_SH-1:0]  hole_off_fld,
    input  logic [AW-RBASE_SH-1:0] range_base_fld,
    output logic [AW-1:0]          addr_raw
);
    logic [AW-1:0] sel_base, hole_off, sel_off, rng_base, offset;
    logic          above4g, base_low;

    assign sel_base = {sel_base_fld, {SBASE_SH{1'b0}}};
    assign hole_off = {{(AW-G4){1'b0}}, hole_off_fld, {HOLE_SH{1'b0}}};
    assign sel_off  = {sel_off_fld, {SOFF_SH{1'b0}}};
    assign rng_base = {range_base_fld, {RBASE_SH{1'b0}}};
    assign above4g  = |addr[AW-1:G4];
    assign base_low = ~|sel_base[AW-1:G4];

    always_comb begin
        if (hi_range)
            offset = (base_low && hole_valid && above4g) ? hole_off : sel_off;
        else
            offset = (hole_valid && above4g) ? hole_off : rng_base;
        addr_raw = addr - offset;
    end
endmodule

// File: rtl/dcn_strip.sv
module dcn_strip
    import dcn_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int IW = ILOG_W
) (
    input  logic [AW-1:0] addr_raw,
    input  logic [IW-1:0] ilog,
    input  chan_src_e     src,
    input  logic [1:0]    ilv_mode,
    output logic [AW-1:0] addr_out
);
    localparam int NCAND = 1 << IW;

    logic [AW-1:0] node_cand [NCAND];
    logic [AW-1:0] node_str;
    logic          chan_ilv;

    for (genvar k = 0; k < NCAND; k++) begin : g_node
        if (k == 0) begin : g_none
            assign node_cand[k] = addr_raw;
        end else begin : g_cut
            assign node_cand[k] = {{k{1'b0}}, addr_raw[AW-1:12+k], addr_raw[11:0]};
        end
    end

    assign node_str = node_cand[ilog];
    assign chan_ilv = (src == SRC_ILV6) || (src == SRC_HASH) || (src == SRC_ILVN);

    always_comb begin
        if (!chan_ilv)
            addr_out = node_str;
        else if (!ilv_mode[0])
            addr_out = {1'b0, node_str[AW-1:7], node_str[5:0]};
        else if (ilv_mode == 2'd1)
            addr_out = {1'b0, node_str[AW-1:13], node_str[11:0]};
        else
            addr_out = {1'b0, node_str[AW-1:10], node_str[8:0]};
    end
endmodule

// File: rtl/dram_chan_norm.sv
module dram_chan_norm
    import dcn_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int IW = ILOG_W,
    parameter int G4 = GIB4_BIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [47:0]   sys_addr,
    input  logic [1:0]    node_ilog,
    input  logic [23:0]   range_base_fld,
    input  logic          hi_rng_en,
    input  logic          hi_chan,
    input  logic          ilv_en,
    input  logic          gang_en,
    input  logic [1:0]    ilv_mode,
    input  logic [20:0]   sel_base_fld,
    input  logic [21:0]   sel_off_fld,
    input  logic          hole_valid,
    input  logic [8:0]    hole_off_fld,
    output logic          out_valid,
    output logic          chan,
    output logic [47:0]   chan_addr,
    output logic          hi_range
);
    logic          hi_nx, chan_nx;
    chan_src_e     src;
    logic [AW-1:0] raw_addr, norm_addr;

    dcn_chan_sel #(.AW(AW), .IW(IW)) u_sel (
        .addr(sys_addr), .ilog(node_ilog), .hi_rng_en(hi_rng_en),
        .hi_chan(hi_chan), .ilv_en(ilv_en), .gang_en(gang_en),
        .ilv_mode(ilv_mode), .sel_base_fld(sel_base_fld),
        .hi_range(hi_nx), .chan(chan_nx), .src(src)
    );

    dcn_offset #(.AW(AW), .G4(G4)) u_off (
        .addr(sys_addr), .hi_range(hi_nx), .sel_base_fld(sel_base_fld),
        .sel_off_fld(sel_off_fld), .hole_valid(hole_valid),
        .hole_off_fld(hole_off_fld), .range_base_fld(range_base_fld),
        .addr_raw(raw_addr)
    );

    dcn_strip #(.AW(AW), .IW(IW)) u_strip (
        .addr_raw(raw_addr), .ilog(node_ilog), .src(src),
        .ilv_mode(ilv_mode), .addr_out(norm_addr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            chan      <= 1'b0;
            chan_addr <= '0;
            hi_range  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                chan      <= chan_nx;
                chan_addr <= norm_addr;
                hi_range  <= hi_nx;
            end
        end
    end

    AST_GANG_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && gang_en |=> !hi_range); // R1
    AST_HIGH_TAKES_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && hi_rng_en && !gang_en && (sys_addr >= {sel_base_fld, 27'b0})
        |=> hi_range && (chan == $past(hi_chan))); // R3
    AST_NO_MODE_CHAN0: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !gang_en && !hi_rng_en && !ilv_en |=> !chan); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(chan_addr) && $stable(chan) && $stable(hi_range)); // R11
    AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> chan_addr[5:0] == $past(sys_addr[5:0])); // R12
endmodule

// File: tb/tb_dram_chan_norm.sv
module tb_dram_chan_norm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [47:0] sys_addr = '0;
    logic [1:0]  node_ilog = '0;
    logic [23:0] range_base_fld = '0;
    logic        hi_rng_en = 1'b0, hi_chan = 1'b0, ilv_en = 1'b0, gang_en = 1'b0;
    logic [1:0]  ilv_mode = '0;
    logic [20:0] sel_base_fld = '0;
    logic [21:0] sel_off_fld = '0;
    logic        hole_valid = 1'b0;
    logic [8:0]  hole_off_fld = '0;
    logic        out_valid, chan, hi_range;
    logic [47:0] chan_addr;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic        e_chan, e_hi;
    logic [47:0] e_addr;
    string       e_tag;

    always #2 clk = ~clk;

    dram_chan_norm dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sys_addr(sys_addr),
        .node_ilog(node_ilog), .range_base_fld(range_base_fld),
        .hi_rng_en(hi_rng_en), .hi_chan(hi_chan), .ilv_en(ilv_en),
        .gang_en(gang_en), .ilv_mode(ilv_mode), .sel_base_fld(sel_base_fld),
        .sel_off_fld(sel_off_fld), .hole_valid(hole_valid),
        .hole_off_fld(hole_off_fld), .out_valid(out_valid), .chan(chan),
        .chan_addr(chan_addr), .hi_range(hi_range)
    );

    function automatic logic [47:0] drop_bit(input logic [47:0] a, input int pos);
        logic [47:0] r = '0;
        int j = 0;
        for (int i = 0; i < 48; i++) begin
            if (i != pos) begin
                r[j] = a[i];
                j++;
            end
        end
        return r;
    endfunction

    function automatic void model();
        logic [47:0] sbase = {sel_base_fld, 27'b0};
        logic [47:0] hole = {16'b0, hole_off_fld, 23'b0};
        logic        big = sys_addr >= 48'h1_0000_0000;
        logic [47:0] off, ca;
        logic        ilv_on;
        e_hi = hi_rng_en && !gang_en && (sys_addr >= sbase);
        if (gang_en) begin e_chan = sys_addr[3]; e_tag = "R2"; end
        else if (e_hi) begin e_chan = hi_chan; e_tag = "R3"; end
        else if (ilv_en && ilv_mode == 0) begin e_chan = sys_addr[6]; e_tag = "R4"; end
        else if (ilv_en && ilv_mode[1]) begin
            e_chan = ($countones(sys_addr[20:16]) % 2 == 1) ^ (ilv_mode[0] ? sys_addr[9] : sys_addr[6]);
            e_tag = "R5";
        end
        else if (ilv_en) begin e_chan = sys_addr[12 + node_ilog]; e_tag = "R6"; end
        else begin e_chan = hi_rng_en ? !hi_chan : 1'b0; e_tag = "R7"; end
        if (e_hi)
            off = (sbase < 48'h1_0000_0000 && hole_valid && big) ? hole : {sel_off_fld, 26'b0};
        else
            off = (hole_valid && big) ? hole : {range_base_fld, 24'b0};
        ca = sys_addr - off;
        for (int k = 0; k < node_ilog; k++) ca = drop_bit(ca, 12);
        ilv_on = ilv_en && !e_hi && !gang_en;
        if (ilv_on) begin
            if (!ilv_mode[0]) ca = drop_bit(ca, 6);
            else if (ilv_mode == 1) ca = drop_bit(ca, 12);
            else ca = drop_bit(ca, 9);
        end
        e_addr = ca;
    endfunction

    task automatic check(input string tag, input logic [47:0] got, input logic [47:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    task automatic run(input string tag);
        in_valid = 1'b1;
        model();
        @(negedge clk);
        check(tag, {47'b0, out_valid}, 48'd1, "out_valid");
        check(tag, {47'b0, chan}, {47'b0, e_chan}, "chan");
        check(tag, chan_addr, e_addr, "chan_addr");
        check(tag, {47'b0, hi_range}, {47'b0, e_hi}, "hi_range");
        check(e_tag, {47'b0, chan}, {47'b0, e_chan}, "chan path");
    endtask

    task automatic clear_cfg();
        hi_rng_en = 0; hi_chan = 0; ilv_en = 0; gang_en = 0; ilv_mode = 0;
        sel_base_fld = 0; sel_off_fld = 0; hole_valid = 0; hole_off_fld = 0;
        range_base_fld = 0; node_ilog = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [47:0] keep_a;
        logic        keep_c;
        void'($urandom(32'd7151));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", {46'b0, out_valid, chan}, 48'd0, "reset valid/chan");
        check("R11", chan_addr, 48'd0, "reset addr");

        // R1 R2: ganged ignores the high range
        clear_cfg(); gang_en = 1; hi_rng_en = 1; sel_base_fld = 0;
        range_base_fld = 24'h000010; sys_addr = 48'h0000_1234_5678; run("R2");
        check("R1", {47'b0, hi_range}, 48'd0, "gang hi");
        // R8: high range with hole
        clear_cfg(); hi_rng_en = 1; hi_chan = 1; sel_base_fld = 21'h10;
        hole_valid = 1; hole_off_fld = 9'h1C0; sel_off_fld = 22'h20;
        sys_addr = 48'h0001_2345_6789; run("R8");
        // R8: base above 4 GiB uses the select offset
        sel_base_fld = 21'h40; sys_addr = 48'h0004_0000_1240; run("R8");
        // R3 R1: just at the boundary
        sel_base_fld = 21'h40; sys_addr = 48'h0002_0000_0000; run("R1");
        // R9: low range, hole and plain base
        clear_cfg(); hole_valid = 1; hole_off_fld = 9'h080; range_base_fld = 24'h000001;
        sys_addr = 48'h0001_0000_0042; run("R9");
        sys_addr = 48'h0000_7000_0042; run("R9");
        // R4 R5 R6 R10 interleave modes with node interleave
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 4; k++) begin
                clear_cfg(); ilv_en = 1; ilv_mode = m[1:0]; node_ilog = k[1:0];
                sys_addr = 48'h00AB_CDEF_5A7C; run(m == 0 ? "R4" : (m == 1 ? "R6" : "R5"));
            end
        end
        clear_cfg(); node_ilog = 3; sys_addr = 48'h0000_0003_F123; run("R10");
        // R7 fallbacks
        clear_cfg(); hi_rng_en = 1; hi_chan = 0; sel_base_fld = 21'h1FFFFF;
        sys_addr = 48'h0000_0000_1000; run("R7");
        check("R7", {47'b0, chan}, 48'd1, "inverse");
        clear_cfg(); sys_addr = 48'h0000_0000_0048; run("R7");
        // R12 wrap
        clear_cfg(); range_base_fld = 24'h000100; sys_addr = 48'h0000_0000_0025; run("R12");
        check("R12", chan_addr, 48'hFFFF_0000_0025, "wrap");
        // R11 hold while idle
        keep_a = chan_addr; keep_c = chan;
        in_valid = 1'b0; sys_addr = 48'h0123_4567_89AB; gang_en = 1;
        @(negedge clk);
        check("R11", {47'b0, out_valid}, 48'd0, "idle valid");
        check("R11", chan_addr, keep_a, "idle addr");
        check("R11", {47'b0, chan}, {47'b0, keep_c}, "idle chan");
        // random mix
        for (int n = 0; n < 3000; n++) begin
            sys_addr = {$urandom, $urandom};
            if ($urandom % 3 == 0) sys_addr[47:32] = '0;
            node_ilog = 2'($urandom); range_base_fld = 24'($urandom % 64);
            hi_rng_en = 1'($urandom); hi_chan = 1'($urandom);
            ilv_en = 1'($urandom); gang_en = ($urandom % 5 == 0);
            ilv_mode = 2'($urandom); sel_base_fld = 21'($urandom % 2048);
            sel_off_fld = 22'($urandom); hole_valid = 1'($urandom);
            hole_off_fld = 9'($urandom);
            run("R13");
        end
        in_valid = 1'b0;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule